// File: doc/BRIEF.md
# RC5 Key Trial Engine

This block judges a single candidate key for the RC5 cipher with 32-bit words and 12 rounds. A start pulse captures an 8-byte key, a 64-bit plaintext and a 64-bit expected ciphertext. The engine then builds the 26-word expanded key table and mixes the key into it, one step per clock. It encrypts the captured plaintext with the finished table, one full round per clock, and finally compares the ciphertext it produced with the expected value.

A search controller places one or more of these engines side by side. It hands each engine a key and waits for the completion pulse. A match pulse marks the key that reproduces the known ciphertext. One rotate-and-add datapath serves the mixing steps, and a second serves the rounds. The engine is therefore iterative and not unrolled: one trial takes a fixed 91 clock cycles.

Top module: `rc5_key_trial`

## Requirements
- R1: On an accepted start, the table word k is set to 0xB7E15163 + k * 0x9E3779B9 modulo 2^32 for k = 0..25, and the working values A and B and both mixing indices start at zero.
- R2: The key is taken little-endian: key byte n is `key_in[8n+7:8n]`, so key word 0 is `key_in[31:0]` and key word 1 is `key_in[63:32]`.
- R3: Mixing makes 78 steps, three passes over the table. Each step sets table word i to A = rotl(S[i] + A + B, 3), then sets key word j to B = rotl(L[j] + A + B, (A + B) mod 32). The index i wraps at 26 and j wraps at 2.
- R4: Encryption starts from A = `pt_in[31:0]` + S[0] and B = `pt_in[63:32]` + S[1]. It then applies 12 rounds of A = rotl(A ^ B, B mod 32) + S[2r] and B = rotl(B ^ A, A mod 32) + S[2r+1]. The result appears on `ct_out` as {B, A}, with A in bits 31:0.
- R5: `done` is high for exactly one cycle, 91 cycles after the clock edge that accepts a start. `busy` is high from the cycle after acceptance until the cycle before `done`, and it is low while `done` is high.
- R6: `match` is high only together with `done`, and exactly when both 32-bit halves of the computed ciphertext equal the expected ciphertext captured at start.
- R7: A start pulse that arrives while busy is ignored. Changes to key, plaintext or expected inputs during a trial do not affect its result or its timing.
- R8: `ct_out` holds its value between completions. It changes only in a cycle where `done` is high.
- R9: A start raised in the cycle where `done` is high is accepted, and `busy` is high in the next cycle.
- R10: After synchronous reset, `busy`, `done` and `match` are low and `ct_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a trial when idle |
| key_in | input | 64 | Candidate key, byte 0 in bits 7:0 |
| pt_in | input | 64 | Known plaintext, word A in bits 31:0 |
| exp_in | input | 64 | Expected ciphertext, word A in bits 31:0 |
| busy | output | 1 | Trial in progress |
| done | output | 1 | One-cycle completion pulse |
| match | output | 1 | Computed ciphertext equals expected, with done |
| ct_out | output | 64 | Last computed ciphertext |

## Verification
The completion of one trial and the acceptance of the next can fall in the same cycle, because the engine returns to idle at the same edge that raises `done`. The bench provokes this by raising `start` with fresh key and block values in the very cycle it sees `done`. It then requires that the first trial's ciphertext and match flag are still reported correctly, that `busy` rises in the next cycle, and that the second trial ends after exactly 91 busy cycles with the reference model's ciphertext.

// File: rtl/rc5_trial_pkg.sv
// Package rc5_trial_pkg
// Shared word type, the table seed constants and the controller state encoding
// for the RC5 key trial engine. Assumes the 32-bit word variant of the cipher.
package rc5_trial_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t SEED_P = 32'hB7E15163;
    localparam word_t SEED_Q = 32'h9E3779B9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MIX  = 2'd1,
        ST_LOAD = 2'd2,
        ST_ENC  = 2'd3
    } trial_state_t;

    // Left rotation by a constant amount: pure rewiring in hardware.
    function automatic word_t rotl_const(input word_t v, input int k);
        return (v << k) | (v >> (WORD_W - k));
    endfunction

endpackage

// File: rtl/rc5_rotl.sv
// Module rc5_rotl
// Data-dependent left rotator for one cipher word. It is built as a barrel
// with radix-4 selector stages on successive pairs of amount bits, then one
// radix-2 stage when the amount width is odd. Assumes WORD_W is a power of two.
module rc5_rotl
    import rc5_trial_pkg::*;
#(
    parameter int AW = $clog2(WORD_W)
) (
    input  word_t         x_in,
    input  logic [AW-1:0] amt,
    output word_t         y_out
);
    localparam int NQ = AW / 2;

    logic [NQ:0][WORD_W-1:0] lvl;

    assign lvl[0] = x_in;

    for (genvar g = 0; g < NQ; g++) begin : g_quad
        localparam int SH = 1 << (2 * g);
        // Four-way select of rotation by 0, 1, 2 or 3 steps of size SH.
        assign lvl[g+1] = (amt[2*g+1:2*g] == 2'd0) ? lvl[g] :
                          (amt[2*g+1:2*g] == 2'd1) ? rotl_const(lvl[g], SH) :
                          (amt[2*g+1:2*g] == 2'd2) ? rotl_const(lvl[g], 2 * SH) :
                                                      rotl_const(lvl[g], 3 * SH);
    end

    if (AW % 2 == 1) begin : g_half
        // Final two-way stage on the top amount bit.
        assign y_out = amt[AW-1] ? rotl_const(lvl[NQ], 1 << (AW - 1)) : lvl[NQ];
    end else begin : g_nohalf
        assign y_out = lvl[NQ];
    end

endmodule

// File: rtl/rc5_mix_unit.sv
// Module rc5_mix_unit
// One key-mixing step: four word additions, a fixed rotation by 3 and one
// data-dependent rotation. Purely combinational; the caller registers results.
module rc5_mix_unit
    import rc5_trial_pkg::*;
(
    input  word_t s_cur,
    input  word_t l_cur,
    input  word_t a_in,
    input  word_t b_in,
    output word_t a_out,
    output word_t b_out
);
    word_t sum_s;
    word_t sum_ab;
    word_t sum_l;

    // New A: table word plus A plus B, rotated left by three.
    assign sum_s  = s_cur + a_in + b_in;
    assign a_out  = rotl_const(sum_s, 3);

    // New B: key word plus new A plus B, rotated by the low bits of A+B.
    assign sum_ab = a_out + b_in;
    assign sum_l  = l_cur + sum_ab;

    rc5_rotl u_rot (
        .x_in (sum_l),
        .amt  (sum_ab[4:0]),
        .y_out(b_out)
    );

endmodule

// File: rtl/rc5_round_unit.sv
// Module rc5_round_unit
// One full encryption round: both half-rounds chained in a single cycle.
// Purely combinational; takes the two table words of this round.
module rc5_round_unit
    import rc5_trial_pkg::*;
(
    input  word_t a_in,
    input  word_t b_in,
    input  word_t s_even,
    input  word_t s_odd,
    output word_t a_out,
    output word_t b_out
);
    word_t rot_a;
    word_t rot_b;
    word_t xa;
    word_t xb;

    // First half: A = ((A ^ B) <<< B) + S[2r].
    assign xa = a_in ^ b_in;
    rc5_rotl u_rot_a (.x_in(xa), .amt(b_in[4:0]), .y_out(rot_a));
    assign a_out = rot_a + s_even;

    // Second half: B = ((B ^ A) <<< A) + S[2r+1], using the new A.
    assign xb = b_in ^ a_out;
    rc5_rotl u_rot_b (.x_in(xb), .amt(a_out[4:0]), .y_out(rot_b));
    assign b_out = rot_b + s_odd;

endmodule

// File: rtl/rc5_key_trial.sv
// Module rc5_key_trial
// Tests one candidate key: seeds and mixes the expanded table (one step per
// clock), encrypts a captured plaintext (one round per clock) and compares the
// result with a captured expected ciphertext. Assumes KEY_WORDS <= table size.
module rc5_key_trial
    import rc5_trial_pkg::*;
#(
    parameter int ROUNDS    = 12,
    parameter int KEY_WORDS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [KEY_WORDS*WORD_W-1:0] key_in,
    input  logic [2*WORD_W-1:0]        pt_in,
    input  logic [2*WORD_W-1:0]        exp_in,
    output logic                       busy,
    output logic                       done,
    output logic                       match,
    output logic [2*WORD_W-1:0]        ct_out
);
    localparam int TABLE_N   = 2 * ROUNDS + 2;
    localparam int MIX_STEPS = 3 * TABLE_N;
    localparam int SI_W      = $clog2(TABLE_N);
    localparam int LJ_W      = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
    localparam int MC_W      = $clog2(MIX_STEPS);
    localparam int RC_W      = $clog2(ROUNDS + 1);

    trial_state_t          state;
    word_t                 s_tab [TABLE_N];
    word_t                 l_tab [KEY_WORDS];
    word_t                 reg_a, reg_b;
    logic [SI_W-1:0]       idx_i;
    logic [LJ_W-1:0]       idx_j;
    logic [MC_W-1:0]       step;
    logic [RC_W-1:0]       rnd;
    logic [RC_W:0]         k_even, k_odd;
    logic [2*WORD_W-1:0]   pt_q, exp_q, ct_q;
    logic                  done_q, match_q;
    word_t                 mix_a, mix_b, rnd_a, rnd_b;
    logic                  accept;

    assign accept = (state == ST_IDLE) && start;
    assign k_even = {rnd, 1'b0};
    assign k_odd  = {rnd, 1'b1};

    rc5_mix_unit u_mix (
        .s_cur(s_tab[idx_i]),
        .l_cur(l_tab[idx_j]),
        .a_in (reg_a),
        .b_in (reg_b),
        .a_out(mix_a),
        .b_out(mix_b)
    );

    rc5_round_unit u_round (
        .a_in  (reg_a),
        .b_in  (reg_b),
        .s_even(s_tab[k_even]),
        .s_odd (s_tab[k_odd]),
        .a_out (rnd_a),
        .b_out (rnd_b)
    );

    // Table storage: seeded on accept, one word of each table rewritten per mix step.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int k = 0; k < TABLE_N; k++) begin
                s_tab[k] <= SEED_P + word_t'(k) * SEED_Q;
            end
            for (int k = 0; k < KEY_WORDS; k++) begin
                l_tab[k] <= key_in[WORD_W*k +: WORD_W];
            end
        end else if (state == ST_MIX) begin
            s_tab[idx_i] <= mix_a;
            l_tab[idx_j] <= mix_b;
        end
    end

    // Sequencer: capture, mix, load the block, run rounds, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            reg_a   <= '0;
            reg_b   <= '0;
            idx_i   <= '0;
            idx_j   <= '0;
            step    <= '0;
            rnd     <= '0;
            pt_q    <= '0;
            exp_q   <= '0;
            ct_q    <= '0;
            done_q  <= 1'b0;
            match_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            match_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_MIX;
                        reg_a <= '0;
                        reg_b <= '0;
                        idx_i <= '0;
                        idx_j <= '0;
                        step  <= '0;
                        pt_q  <= pt_in;
                        exp_q <= exp_in;
                    end
                end
                ST_MIX: begin
                    reg_a <= mix_a;
                    reg_b <= mix_b;
                    idx_i <= (idx_i == SI_W'(TABLE_N - 1)) ? '0 : idx_i + 1'b1;
                    idx_j <= (idx_j == LJ_W'(KEY_WORDS - 1)) ? '0 : idx_j + 1'b1;
                    step  <= step + 1'b1;
                    if (step == MC_W'(MIX_STEPS - 1)) begin
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    reg_a <= pt_q[WORD_W-1:0] + s_tab[0];
                    reg_b <= pt_q[2*WORD_W-1:WORD_W] + s_tab[1];
                    rnd   <= RC_W'(1);
                    state <= ST_ENC;
                end
                ST_ENC: begin
                    reg_a <= rnd_a;
                    reg_b <= rnd_b;
                    rnd   <= rnd + 1'b1;
                    if (rnd == RC_W'(ROUNDS)) begin
                        state   <= ST_IDLE;
                        done_q  <= 1'b1;
                        ct_q    <= {rnd_b, rnd_a};
                        match_q <= ({rnd_b, rnd_a} == exp_q);
                    end
                end
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = done_q;
    assign match  = match_q;
    assign ct_out = ct_q;

endmodule

// File: rtl/rc5_key_trial_chk.sv
// Module rc5_key_trial_chk
// Port-level protocol checks for rc5_key_trial. A counter of busy cycles
// checks the fixed trial length without a deep $past.
module rc5_key_trial_chk #(
    parameter int ROUNDS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        match,
    input logic [63:0] ct_out
);
    localparam int LAT   = 3 * (2 * ROUNDS + 2) + ROUNDS + 1;
    localparam int CNT_W = $clog2(LAT + 2);

    logic [CNT_W-1:0] busy_cnt;

    // Count consecutive busy cycles; restart whenever the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else        busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_fixed_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == CNT_W'(LAT)));

    p_match_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> done);

    p_ct_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ct_out) |-> done);

    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (busy_cnt < CNT_W'(LAT - 1))) |=> busy);

    p_idle_start_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

endmodule

bind rc5_key_trial rc5_key_trial_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .match (match),
    .ct_out(ct_out)
);

// File: tb/sim_rc5_key_trial.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes reference results, the monitor pops
// and compares them whenever done is seen.
module sim_rc5_key_trial;

    localparam int LAT = 91;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [63:0] key_in, pt_in, exp_in;
    logic        busy, done, match;
    logic [63:0] ct_out;

    always #2.5 clk = ~clk;

    rc5_key_trial u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
        .pt_in(pt_in), .exp_in(exp_in), .busy(busy), .done(done),
        .match(match), .ct_out(ct_out)
    );

    typedef struct {
        logic [63:0] ct;
        logic        m;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          errors = 0;
    int          busy_cnt = 0;
    logic [63:0] last_ct = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] v, input logic [31:0] n);
        int k;
        k = int'(n[4:0]);
        return (k == 0) ? v : ((v << k) | (v >> (32 - k)));
    endfunction

    // Behavioural cipher model: seed, mix, encrypt (R1..R4).
    function automatic logic [63:0] ref_ct(input logic [63:0] key, input logic [63:0] pt);
        logic [31:0] s [26];
        logic [31:0] l [2];
        logic [31:0] a, b;
        int i, j;
        for (int k = 0; k < 26; k++) s[k] = 32'hB7E15163 + 32'(k) * 32'h9E3779B9;
        l[0] = key[31:0];
        l[1] = key[63:32];
        a = '0; b = '0; i = 0; j = 0;
        for (int n = 0; n < 78; n++) begin
            a = rl(s[i] + a + b, 32'd3);
            s[i] = a;
            b = rl(l[j] + a + b, a + b);
            l[j] = b;
            i = (i + 1) % 26;
            j = (j + 1) % 2;
        end
        a = pt[31:0] + s[0];
        b = pt[63:32] + s[1];
        for (int r = 1; r <= 12; r++) begin
            a = rl(a ^ b, b) + s[2*r];
            b = rl(b ^ a, a) + s[2*r+1];
        end
        return {b, a};
    endfunction

    // Driver: queue the reference outcome, then pulse start for one cycle.
    task automatic launch(input logic [63:0] k, input logic [63:0] p,
                          input logic [63:0] e, input string tag);
        item_t it;
        it.ct  = ref_ct(k, p);
        it.m   = (e == it.ct);
        it.tag = tag;
        sb.push_back(it);
        key_in = k; pt_in = p; exp_in = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    // Monitor: busy-length, ciphertext and match flag at each completion.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (busy) busy_cnt++;
            if (done) begin
                item_t it;
                chk(busy_cnt == LAT, "R5", "busy cycles before done", 64'(busy_cnt), 64'(LAT));
                busy_cnt = 0;
                if (sb.size() == 0) begin
                    chk(1'b0, "R5", "done with empty scoreboard", 64'(done), 64'd0);
                end else begin
                    it = sb.pop_front();
                    chk(ct_out == it.ct, "R1 R2 R3 R4", {"ciphertext ", it.tag}, ct_out, it.ct);
                    chk(match == it.m, "R6", {"match flag ", it.tag}, 64'(match), 64'(it.m));
                    chk(!busy, "R5", {"busy low with done ", it.tag}, 64'(busy), 64'd0);
                end
                last_ct = ct_out;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r;
        rst_n = 1'b0; start = 1'b0; key_in = '0; pt_in = '0; exp_in = '0;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0, "R10", "busy in reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R10", "done in reset", 64'(done), 64'd0);
        chk(match == 1'b0, "R10", "match in reset", 64'(match), 64'd0);
        chk(ct_out == '0, "R10", "ct in reset", ct_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4: all-zero key and block, mismatching expected value
        launch(64'd0, 64'd0, 64'd0, "zero key");
        wait_done();

        // R2 R6: byte-ordered key with matching expected value
        r = ref_ct(64'h0706050403020100, 64'h89ABCDEF01234567);
        launch(64'h0706050403020100, 64'h89ABCDEF01234567, r, "match");
        wait_done();

        // R6: one bit off in the high word gives no match
        launch(64'h0706050403020100, 64'h89ABCDEF01234567, r ^ 64'h1_0000_0000, "near miss");
        wait_done();

        // R7 R8: start and new inputs mid-trial are ignored; ct holds
        r = ref_ct(64'hFEDCBA9876543210, 64'h0);
        launch(64'hFEDCBA9876543210, 64'h0, r, "ignored start");
        repeat (20) @(negedge clk);
        chk(ct_out == last_ct, "R8", "ct held during trial", ct_out, last_ct);
        key_in = 64'h1111; pt_in = 64'h2222; exp_in = 64'h3333; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7", "busy after ignored start", 64'(busy), 64'd1);
        wait_done();
        @(negedge clk);
        chk(busy == 1'b0, "R7", "no second trial from ignored start", 64'(busy), 64'd0);

        // R9: start raised in the done cycle is accepted
        launch(64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF, 64'h0, "first of pair");
        wait_done();
        r = ref_ct(64'hA5A5A5A55A5A5A5A, 64'h00000001_80000000);
        launch(64'hA5A5A5A55A5A5A5A, 64'h00000001_80000000, r, "second of pair");
        chk(busy == 1'b1, "R9", "busy after start in done cycle", 64'(busy), 64'd1);
        wait_done();
        repeat (2) @(negedge clk);

        chk(sb.size() == 0, "R5", "all trials completed", 64'(sb.size()), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule